// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Takeover

This block is one bidirectional I/O port of a microcontroller-style chip. A processor controls it through three memory-mapped registers on a small read/write bus. The direction register uses 1 for input and 0 for output. The output latch holds the values that output pins drive. The pin-level register returns what the pads actually carry, after a two-flop synchroniser. Writing either the pin-level address or the latch address loads the latch, and reading the latch returns the stored values. Read-modify-write on the latch is therefore immune to pin loading.

On-chip peripherals can claim individual pins. A claimed pin is forced to input or to output whatever the direction register holds, and a forced output drives the peripheral's value. The direction register still reads back exactly what software wrote. A pin forced to input hands its synchronised level back to the claiming peripheral.

One relocatable peripheral signal can be placed on either of two pins, chosen by a static select input. The pin that is not chosen stays under register control.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, the direction register reads all ones, the output latch reads zero and no pad output enable is active.
- R2: With no takeover on a pin, a direction bit of 1 turns that pad's output enable off, and a direction bit of 0 turns it on with the pad output equal to the latch bit.
- R3: A read of address 1 returns the latch contents, not the pad levels.
- R4: A write to address 0 or address 1 loads the output latch at the next clock edge. A write to address 2 loads the direction register at the next clock edge.
- R5: A read of address 0 returns the pad input levels after two clock edges of synchronisation.
- R6: A takeover request on a pin sets its output enable to the inverse of the request's direction bit (1 = force input, 0 = force output). A forced output drives the peripheral's value.
- R7: Reading address 2 returns the last written direction value while takeovers are active.
- R8: A pin forced to input by a per-pin takeover presents its synchronised level on the matching bit of the peripheral input bus. Every other bit of that bus is 0.
- R9: When the relocatable function is enabled, select 0 puts it on pin 3 and select 1 puts it on pin 5. The unselected pin follows the direction and latch registers.
- R10: With the relocatable function enabled in input mode, its input output carries the synchronised level of the selected pin. Otherwise it is 0.
- R11: A write to address 3 changes no register, and a read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 pins, 1 latch, 2 direction) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| ovr_en | input | 8 | Per-pin takeover request |
| ovr_dir | input | 8 | Takeover direction, 1 = force input |
| ovr_out | input | 8 | Peripheral output value for forced outputs |
| periph_in | output | 8 | Synchronised levels of pins forced to input |
| reloc_sel | input | 1 | Static location select of the relocatable function |
| reloc_en | input | 1 | Relocatable function active |
| reloc_dir | input | 1 | Relocatable function direction, 1 = input |
| reloc_out | input | 1 | Relocatable function output value |
| reloc_in | output | 1 | Synchronised level of the selected pin |

## Verification
Corruption in the direction register shows up on pad_oe in the cycle after the write, and on a readback of address 2 even while a takeover masks the pads. A bad latch appears on pad_out for output pins and on address 1 at once. A synchroniser fault moves the edge at which address 0 and periph_in change away from exactly two clocks after the pad changes. A wrong location decode drives or releases the wrong one of pins 3 and 5 combinationally, in the same cycle the select changes.

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
  parameter int W     = 8,
  parameter int SYNC  = 2,
  parameter int PIN_A = 3,
  parameter int PIN_B = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  input  logic [W-1:0] ovr_en,
  input  logic [W-1:0] ovr_dir,
  input  logic [W-1:0] ovr_out,
  output logic [W-1:0] periph_in,
  input  logic         reloc_sel,
  input  logic         reloc_en,
  input  logic         reloc_dir,
  input  logic         reloc_out,
  output logic         reloc_in
);
  localparam int SELW = (W > 1) ? $clog2(W) : 1;
  localparam logic [1:0] A_PIN = 2'd0;
  localparam logic [1:0] A_LAT = 2'd1;
  localparam logic [1:0] A_DIR = 2'd2;
  localparam logic [SELW-1:0] LOC_A = SELW'(PIN_A);
  localparam logic [SELW-1:0] LOC_B = SELW'(PIN_B);

  logic [W-1:0] lat_q, dir_q;
  logic [W-1:0] sync_q [SYNC];
  logic [W-1:0] pin_s;
  logic [SELW-1:0] reloc_pin;
  logic [W-1:0] reloc_mask, own, force_in, ovr_only;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else if (bus_we) begin
      if (bus_addr == A_PIN || bus_addr == A_LAT) lat_q <= bus_wdata;
      if (bus_addr == A_DIR) dir_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC; k++) sync_q[k] <= '0;
    end else begin
      sync_q[0] <= pad_in;
      for (int k = 1; k < SYNC; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  assign pin_s = sync_q[SYNC-1];

  always_comb begin
    case (bus_addr)
      A_PIN:   bus_rdata = pin_s;
      A_LAT:   bus_rdata = lat_q;
      A_DIR:   bus_rdata = dir_q;
      default: bus_rdata = '0;
    endcase
  end

  assign reloc_pin  = reloc_sel ? LOC_B : LOC_A;
  assign reloc_mask = {{(W-1){1'b0}}, reloc_en} << reloc_pin;
  assign ovr_only   = ovr_en & ~reloc_mask;
  assign own        = ovr_en | reloc_mask;
  assign force_in   = (ovr_only & ovr_dir) | (reloc_mask & {W{reloc_dir}});

  assign pad_oe  = (own & ~force_in) | (~own & ~dir_q);
  assign pad_out = (reloc_mask & {W{reloc_out}}) | (ovr_only & ovr_out) | (~own & lat_q);

  assign periph_in = pin_s & ovr_only & ovr_dir;
  assign reloc_in  = reloc_en & reloc_dir & pin_s[reloc_pin];
endmodule

module gpio_ovr_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_we,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] ovr_en,
  input logic [W-1:0] ovr_dir,
  input logic         reloc_en,
  input logic [W-1:0] lat_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] pin_s
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  p_reset_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0 && !bus_we && ovr_en == '0 && !reloc_en) |-> pad_oe == '0);

  p_dir_to_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd2) |=> ((ovr_en == '0 && !reloc_en) -> pad_oe == ~$past(bus_wdata)));

  p_latch_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == 2'd0 || bus_addr == 2'd1)) |=> lat_q == $past(bus_wdata));

  p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> pin_s == $past(pad_in, 2));

  p_force_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reloc_en |-> ((pad_oe & ovr_en) == (ovr_en & ~ovr_dir)));

  p_dir_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == 2'd2) |=> $stable(dir_q));

  p_addr3_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd3) |=> ($stable(lat_q) && $stable(dir_q)));
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_in(pad_in), .pad_oe(pad_oe),
  .ovr_en(ovr_en), .ovr_dir(ovr_dir), .reloc_en(reloc_en),
  .lat_q(lat_q), .dir_q(dir_q), .pin_s(pin_s)
);

// File: tb/test_gpio_ovr_port.sv
`timescale 1ns/1ps
module test_gpio_ovr_port;
  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [7:0] pad_in = 0, pad_out, pad_oe;
  logic [7:0] ovr_en = 0, ovr_dir = 0, ovr_out = 0, periph_in;
  logic reloc_sel = 0, reloc_en = 0, reloc_dir = 0, reloc_out = 0, reloc_in;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_ovr_port i_gpio_ovr_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .ovr_en(ovr_en), .ovr_dir(ovr_dir),
    .ovr_out(ovr_out), .periph_in(periph_in), .reloc_sel(reloc_sel),
    .reloc_en(reloc_en), .reloc_dir(reloc_dir), .reloc_out(reloc_out),
    .reloc_in(reloc_in));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; #0.5;
    d = bus_rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2, v); chk("R1 dir reset", v, 8'hFF);
    rd(1, v); chk("R1 latch reset", v, 8'h00);
    chk("R1 oe reset", pad_oe, 8'h00);
  endtask

  task automatic t_dir_latch;
    logic [7:0] v;
    wr(2, 8'hCF); chk("R2 oe from dir", pad_oe, 8'h30);
    wr(1, 8'hA5); chk("R2/R4 pad_out from latch", pad_out, 8'hA5);
    wr(0, 8'h3C);
    rd(1, v); chk("R4 port write loads latch", v, 8'h3C);
    pad_in = 8'h00; settle(3);
    rd(1, v); chk("R3 latch read ignores pins", v, 8'h3C);
    rd(0, v); chk("R3 pin read is pin level", v, 8'h00);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    @(negedge clk); bus_addr = 0; pad_in = 8'h5A;
    @(posedge clk); #1; chk("R5 one edge not yet", bus_rdata, 8'h00);
    @(posedge clk); #1; chk("R5 after two edges", bus_rdata, 8'h5A);
    rd(0, v); chk("R5 stable read", v, 8'h5A);
  endtask

  task automatic t_override;
    logic [7:0] v;
    wr(2, 8'hFF);
    @(negedge clk); ovr_en = 8'h03; ovr_dir = 8'h02; ovr_out = 8'h01; #0.5;
    chk("R6 forced out/in oe", pad_oe, 8'h01);
    chk("R6 forced out value", pad_out & 8'h01, 8'h01);
    rd(2, v); chk("R7 dir reads written value", v, 8'hFF);
    wr(2, 8'h00);
    chk("R6 forced input over output dir", pad_oe, 8'hFD);
    rd(2, v); chk("R7 dir reads 00 under override", v, 8'h00);
    @(negedge clk); pad_in = 8'h06; settle(2);
    chk("R8 periph_in only forced input", periph_in, 8'h02);
    @(negedge clk); ovr_en = 0; ovr_dir = 0; ovr_out = 0; #0.5;
    chk("R8 periph_in zero without override", periph_in, 8'h00);
  endtask

  task automatic t_reloc;
    wr(2, 8'hFF); wr(1, 8'hFF);
    @(negedge clk); reloc_en = 1; reloc_dir = 0; reloc_out = 0; reloc_sel = 0; #0.5;
    chk("R9 select 0 drives pin 3", pad_oe, 8'h08);
    chk("R9 pin 3 value", pad_out & 8'h08, 8'h00);
    @(negedge clk); reloc_sel = 1; #0.5;
    chk("R9 select 1 drives pin 5", pad_oe, 8'h20);
    wr(2, 8'h00);
    chk("R9 unselected pin 3 is gpio", pad_oe, 8'hFF);
    chk("R9 pad_out mix", pad_out, 8'hDF);
    @(negedge clk); reloc_dir = 1; pad_in = 8'h20; settle(2);
    chk("R10 reloc_in from pin 5", {7'd0, reloc_in}, 8'h01);
    chk("R10 input mode releases pin 5", pad_oe, 8'hDF);
    @(negedge clk); pad_in = 8'h08; settle(2);
    chk("R10 pin 3 not sampled", {7'd0, reloc_in}, 8'h00);
    @(negedge clk); reloc_sel = 0; #0.5;
    chk("R10 select 0 samples pin 3", {7'd0, reloc_in}, 8'h01);
    @(negedge clk); reloc_en = 0; reloc_dir = 0; reloc_sel = 0; #0.5;
  endtask

  task automatic t_addr3;
    logic [7:0] v;
    wr(2, 8'h0F); wr(1, 8'h99);
    wr(3, 8'h55);
    rd(2, v); chk("R11 dir untouched", v, 8'h0F);
    rd(1, v); chk("R11 latch untouched", v, 8'h99);
    rd(3, v); chk("R11 addr3 reads zero", v, 8'h00);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_dir_latch;
    t_sync;
    t_override;
    t_reloc;
    t_addr3;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule